// File: doc/BRIEF.md
# Pipelined March Self-Test Engine for a Single-Port SRAM

This block tests one single-port synchronous SRAM with its own logic. While `test_mode` is high, a multiplexer stage gives the engine control of every memory input: chip enable, write enable, address, byte enables and write data. While `test_mode` is low, the functional inputs pass straight through to the memory. A `start` pulse launches a fixed March algorithm. The engine walks the address space several times, and on each walk it writes and reads cells against a data background. It compares every returned word with the word it expects and keeps a sticky failure flag.

The engine issues one memory access on every clock and never leaves a gap between accesses. It does not compare inside the issue path. Instead, each read's expected word and a valid bit travel down a pipeline that has the same depth as the memory read latency, and the compare happens when the data returns. The run covers these elements:
- six March elements, one of which reads the same cell twice to catch reads that disturb the cell;
- an element that walks addresses in a folded order to expose address-line faults;
- a final element that drives one byte enable at a time to expose shorted enables.

Top module: `mbist_march_engine`

## Requirements
- R1: With `test_mode` low, all memory outputs equal the functional inputs. With `test_mode` high and no run in progress, `mem_ce` is 0.
- R2: `start` is taken only when the engine is idle and `test_mode` is high. The first access appears on the memory pins in the second cycle after the clock edge that samples `start`. A `start` that arrives during a run, or while `test_mode` is low, changes nothing.
- R3: A run issues one access per cycle with no idle gaps, in this order. Under background 0, and then again under background 1, it runs these elements: e0 ascending {w0}; e1 ascending {r0,w1}; e2 ascending {r1,w0}; e3 descending {r0,w1}; e4 descending {r1,w0}; e5 descending {r0,r0}; e6 folded {r0,w1}. After that it runs the lane element once for each byte lane, lowest lane first.
- R4: Step i of an ascending walk uses address i. Step i of a descending walk uses address DEPTH-1-i. Step i of a folded walk uses address i/2 when i is even and DEPTH-1-(i-1)/2 when i is odd.
- R5: A "0" operation uses the background word and a "1" operation uses its bitwise complement. Background 0 is all zeros. In background 1, bit b of the word at address a equals (a+b) mod 2, so even addresses hold ...1010 and odd addresses hold ...0101.
- R6: Element e5 reads each cell twice in consecutive cycles, and both reads expect the background word. A cell that a read flips is therefore reported.
- R7: The lane element for lane k walks ascending with {write, read}. The write sends the background-1 word with only byte enable k set. The read expects lanes 0..k to hold the background-1 word and the higher lanes to hold its complement.
- R8: Every read drives all byte enables high, and every March write (e0 to e6) also drives all byte enables high.
- R9: A read whose returned word differs from its expected word sets `fail` in cycle c+RD_LAT+1, where c is the cycle in which the read was on the pins.
- R10: `fail` is 0 after reset. Once set, it holds until the next accepted `start`, which clears it in the following cycle.
- R11: `done` is high for exactly one cycle, RD_LAT+1 cycles after the cycle of the last access. `done` is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | Gives the engine control of the memory pins |
| start | input | 1 | Launches a run when idle in test mode |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Sticky mismatch flag |
| func_ce | input | 1 | Functional chip enable |
| func_we | input | 1 | Functional write enable |
| func_addr | input | ADDR_W | Functional address |
| func_be | input | DATA_W/8 | Functional byte enables |
| func_wdata | input | DATA_W | Functional write data |
| mem_ce | output | 1 | Memory chip enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_be | output | DATA_W/8 | Memory byte enables |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid RD_LAT cycles after the read |

## Verification
The bench builds the engine with ADDR_W=4, DATA_W=16 and RD_LAT=2. The 16-word depth keeps a full run of both backgrounds plus the lane elements under 500 accesses, so the bench can compare every access in every run. Two byte lanes make the lane element's partial-merge expectation observable. A latency of 2 means the expected word crosses more than one pipeline stage. The bench's memory model can inject a stuck bit, a read that flips its cell, and an enable short between lanes. Each fault is reachable only through a different part of the sequence.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   typedef enum logic [1:0] {DIR_UP, DIR_DOWN, DIR_FOLD} walk_e;

   typedef enum logic [2:0] {OP_W0, OP_W1, OP_R0, OP_R1, OP_WLANE, OP_RLANE} opk_e;

   typedef struct packed {
      walk_e walk;
      logic  dual;
      opk_e  first;
      opk_e  second;
   } elem_t;

   localparam logic [2:0] EL_LAST_MARCH = 3'd6;
   localparam logic [2:0] EL_LANE       = 3'd7;

   // Element table: walk order and the one or two operations applied per cell.
   function automatic elem_t elem_info(input logic [2:0] el);
      elem_t e;
      case (el)
         3'd0:    e = '{DIR_UP,   1'b0, OP_W0, OP_W0};
         3'd1:    e = '{DIR_UP,   1'b1, OP_R0, OP_W1};
         3'd2:    e = '{DIR_UP,   1'b1, OP_R1, OP_W0};
         3'd3:    e = '{DIR_DOWN, 1'b1, OP_R0, OP_W1};
         3'd4:    e = '{DIR_DOWN, 1'b1, OP_R1, OP_W0};
         3'd5:    e = '{DIR_DOWN, 1'b1, OP_R0, OP_R0};
         3'd6:    e = '{DIR_FOLD, 1'b1, OP_R0, OP_W1};
         default: e = '{DIR_UP,   1'b1, OP_WLANE, OP_RLANE};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
   import mbist_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  step,
   output logic                  final_op,
   output logic [ADDR_W-1:0]     op_addr,
   output logic                  op_we,
   output logic [DATA_W/8-1:0]   op_be,
   output logic [DATA_W-1:0]     op_wdata,
   output logic [DATA_W-1:0]     op_exp
);

   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [DATA_W-1:0] PAT_EVEN = {(DATA_W/2){2'b10}};
   localparam logic [DATA_W-1:0] PAT_ODD  = ~PAT_EVEN;

   logic              bg;
   logic [2:0]        el;
   logic [LANE_W-1:0] lane;
   logic [ADDR_W-1:0] idx;
   logic              ph;

   elem_t             info;
   opk_e              kind;
   logic [ADDR_W-1:0] half;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] d0, d1, low_mask, merged;
   logic [LANES-1:0]  lane_hot;
   logic              phase_end, elem_end;

   // Per-lane decode: single-lane enable and the "already rewritten" mask.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_hot[g]          = (lane == LANE_W'(g));
      assign low_mask[g*8 +: 8]   = (LANE_W'(g) <= lane) ? 8'hFF : 8'h00;
   end

   always_comb begin
      info = elem_info(el);
      kind = ph ? info.second : info.first;
      half = {1'b0, idx[ADDR_W-1:1]};
      case (info.walk)
         DIR_DOWN: addr = ~idx;
         DIR_FOLD: addr = idx[0] ? ~half : half;
         default:  addr = idx;
      endcase
      d0     = bg ? (addr[0] ? PAT_ODD : PAT_EVEN) : '0;
      d1     = ~d0;
      merged = (d0 & low_mask) | (d1 & ~low_mask);

      op_addr  = addr;
      op_we    = 1'b0;
      op_be    = '1;
      op_wdata = '0;
      op_exp   = '0;
      case (kind)
         OP_W0:    begin op_we = 1'b1; op_wdata = d0; end
         OP_W1:    begin op_we = 1'b1; op_wdata = d1; end
         OP_R0:    op_exp = d0;
         OP_R1:    op_exp = d1;
         OP_WLANE: begin op_we = 1'b1; op_wdata = d0; op_be = lane_hot; end
         default:  op_exp = merged;
      endcase
   end

   assign phase_end = info.dual ? ph : 1'b1;
   assign elem_end  = phase_end & (&idx);
   assign final_op  = (el == EL_LANE) && (lane == LANE_W'(LANES-1)) && elem_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bg   <= 1'b0;
         el   <= '0;
         lane <= '0;
         idx  <= '0;
         ph   <= 1'b0;
      end else if (clear) begin
         bg   <= 1'b0;
         el   <= '0;
         lane <= '0;
         idx  <= '0;
         ph   <= 1'b0;
      end else if (step) begin
         if (!phase_end) begin
            ph <= 1'b1;
         end else begin
            ph  <= 1'b0;
            idx <= idx + 1'b1;
            if (&idx) begin
               if (el == EL_LAST_MARCH) begin
                  if (!bg) begin
                     bg <= 1'b1;
                     el <= '0;
                  end else begin
                     el   <= EL_LANE;
                     lane <= '0;
                  end
               end else if (el == EL_LANE) begin
                  lane <= lane + 1'b1;
               end else begin
                  el <= el + 3'd1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/mbist_rdpipe.sv
module mbist_rdpipe #(
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_exp,
   input  logic [DATA_W-1:0] rdata,
   output logic              mismatch
);

   logic [RD_LAT-1:0]             vld;
   logic [RD_LAT-1:0][DATA_W-1:0] expq;

   // Expected word rides alongside the read so it lines up with returned data.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= '0;
         expq <= '0;
      end else begin
         vld[0]  <= push;
         expq[0] <= push_exp;
         for (int s = 1; s < RD_LAT; s++) begin
            vld[s]  <= vld[s-1];
            expq[s] <= expq[s-1];
         end
      end
   end

   assign mismatch = vld[RD_LAT-1] && (rdata != expq[RD_LAT-1]);

endmodule

// File: rtl/mbist_march_engine.sv
module mbist_march_engine #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                test_mode,
   input  logic                start,
   output logic                done,
   output logic                fail,
   input  logic                func_ce,
   input  logic                func_we,
   input  logic [ADDR_W-1:0]   func_addr,
   input  logic [DATA_W/8-1:0] func_be,
   input  logic [DATA_W-1:0]   func_wdata,
   output logic                mem_ce,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata
);

   localparam int LANES = DATA_W / 8;
   localparam int CNT_W = $clog2(RD_LAT + 2);

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 2) begin : g_bad_depth
      $error("ADDR_W must be at least 2");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_e;

   state_e            state;
   logic [CNT_W-1:0]  drain_cnt;
   logic              accept;
   logic              final_op;
   logic              mismatch;

   logic [ADDR_W-1:0] op_addr;
   logic              op_we;
   logic [LANES-1:0]  op_be;
   logic [DATA_W-1:0] op_wdata, op_exp;

   logic              iss_ce, iss_we;
   logic [ADDR_W-1:0] iss_addr;
   logic [LANES-1:0]  iss_be;
   logic [DATA_W-1:0] iss_wdata, iss_exp;

   assign accept = (state == ST_IDLE) && test_mode && start;

   mbist_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .step     (state == ST_RUN),
      .final_op (final_op),
      .op_addr  (op_addr),
      .op_we    (op_we),
      .op_be    (op_be),
      .op_wdata (op_wdata),
      .op_exp   (op_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         drain_cnt <= '0;
         done      <= 1'b0;
         fail      <= 1'b0;
         iss_ce    <= 1'b0;
         iss_we    <= 1'b0;
         iss_addr  <= '0;
         iss_be    <= '0;
         iss_wdata <= '0;
         iss_exp   <= '0;
      end else begin
         done      <= 1'b0;
         // Issue register: decode depth stays off the memory pins.
         iss_ce    <= (state == ST_RUN);
         iss_we    <= (state == ST_RUN) && op_we;
         iss_be    <= (state == ST_RUN) ? op_be : '0;
         iss_addr  <= op_addr;
         iss_wdata <= op_wdata;
         iss_exp   <= op_exp;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state <= ST_RUN;
                  fail  <= 1'b0;
               end
            end
            ST_RUN: begin
               if (final_op) begin
                  state     <= ST_DRAIN;
                  drain_cnt <= CNT_W'(RD_LAT + 1);
               end
            end
            default: begin
               if (drain_cnt == CNT_W'(1)) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  drain_cnt <= drain_cnt - 1'b1;
               end
            end
         endcase
         if (mismatch) fail <= 1'b1;
      end
   end

   mbist_rdpipe #(
      .DATA_W (DATA_W),
      .RD_LAT (RD_LAT)
   ) u_rdpipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (iss_ce && !iss_we),
      .push_exp (iss_exp),
      .rdata    (mem_rdata),
      .mismatch (mismatch)
   );

   assign mem_ce    = test_mode ? iss_ce    : func_ce;
   assign mem_we    = test_mode ? iss_we    : func_we;
   assign mem_addr  = test_mode ? iss_addr  : func_addr;
   assign mem_be    = test_mode ? iss_be    : func_be;
   assign mem_wdata = test_mode ? iss_wdata : func_wdata;

endmodule

// File: rtl/mbist_march_engine_chk.sv
module mbist_march_engine_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                test_mode,
   input logic                start,
   input logic                done,
   input logic                fail,
   input logic                mem_ce,
   input logic                mem_we,
   input logic [DATA_W/8-1:0] mem_be
);

   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (done && test_mode) |-> !mem_ce);

   a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> fail);

   a_r8_read_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && mem_ce && !mem_we) |-> (&mem_be));

   a_r7_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && mem_ce && mem_we) |-> ((&mem_be) || ($countones(mem_be) == 1)));

endmodule

bind mbist_march_engine mbist_march_engine_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .test_mode (test_mode),
   .start     (start),
   .done      (done),
   .fail      (fail),
   .mem_ce    (mem_ce),
   .mem_we    (mem_we),
   .mem_be    (mem_be)
);

// File: tb/mbist_march_engine_bench.sv
module mbist_march_engine_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 4;
   localparam int DW    = 16;
   localparam int RL    = 2;
   localparam int NB    = DW / 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          test_mode, start;
   logic          done, fail;
   logic          func_ce, func_we;
   logic [AW-1:0] func_addr;
   logic [NB-1:0] func_be;
   logic [DW-1:0] func_wdata;
   logic          mem_ce, mem_we;
   logic [AW-1:0] mem_addr;
   logic [NB-1:0] mem_be;
   logic [DW-1:0] mem_wdata, mem_rdata;

   int n_chk = 0;
   int n_bad = 0;
   int fault_mode = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbist_march_engine #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(RL)) u_mbist_march_engine (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
      .done(done), .fail(fail),
      .func_ce(func_ce), .func_we(func_we), .func_addr(func_addr),
      .func_be(func_be), .func_wdata(func_wdata),
      .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // Memory model with injectable faults:
   // 1 = bit0 of word 3 reads as 1; 2 = reading word 5 flips its bit 2; 3 = enable 0 also writes lane 1.
   logic [DW-1:0] arr [DEPTH];
   logic [DW-1:0] rq  [RL];
   assign mem_rdata = rq[RL-1];

   function automatic logic [DW-1:0] peek(input int a);
      logic [DW-1:0] v = arr[a];
      if (fault_mode == 1 && a == 3) v[0] = 1'b1;
      return v;
   endfunction

   always @(posedge clk) begin
      for (int i = 1; i < RL; i++) rq[i] <= rq[i-1];
      if (mem_ce) begin
         if (mem_we) begin
            for (int l = 0; l < NB; l++)
               if (mem_be[l] || (fault_mode == 3 && l == 1 && mem_be[0]))
                  arr[mem_addr][l*8 +: 8] <= mem_wdata[l*8 +: 8];
         end else begin
            rq[0] <= peek(int'(mem_addr));
            if (fault_mode == 2 && mem_addr == AW'(5)) arr[5] <= arr[5] ^ DW'(4);
         end
      end
   end

   // Reference access list, built from the requirements.
   int            q_addr[$];
   int            q_we[$];
   int            q_be[$];
   int            q_el[$];
   logic [DW-1:0] q_dat[$];

   function automatic logic [DW-1:0] bgword(input int bg, input int a);
      logic [DW-1:0] w = '0;
      if (bg != 0) for (int b = 0; b < DW; b++) w[b] = ((a + b) % 2) != 0;
      return w;
   endfunction

   function automatic int walk_addr(input int dir, input int i);
      if (dir == 1) return DEPTH - 1 - i;
      if (dir == 2) return (i % 2 == 0) ? i / 2 : DEPTH - 1 - (i - 1) / 2;
      return i;
   endfunction

   task automatic add_op(input int el, input int a, input int we, input int be, input logic [DW-1:0] d);
      q_el.push_back(el); q_addr.push_back(a); q_we.push_back(we);
      q_be.push_back(be); q_dat.push_back(d);
   endtask

   // kinds: 0=w0 1=w1 2=r0 3=r1 -1=none
   task automatic add_kind(input int el, input int bg, input int a, input int kind);
      logic [DW-1:0] d = bgword(bg, a);
      case (kind)
         0: add_op(el, a, 1, (1 << NB) - 1, d);
         1: add_op(el, a, 1, (1 << NB) - 1, ~d);
         2: add_op(el, a, 0, (1 << NB) - 1, d);
         3: add_op(el, a, 0, (1 << NB) - 1, ~d);
         default: ;
      endcase
   endtask

   task automatic build_ops();
      int k0 [7] = '{0, 2, 3, 2, 3, 2, 2};
      int k1 [7] = '{-1, 1, 0, 1, 0, 2, 1};
      int dr [7] = '{0, 0, 0, 1, 1, 1, 2};
      for (int bg = 0; bg < 2; bg++)
         for (int el = 0; el < 7; el++)
            for (int i = 0; i < DEPTH; i++) begin
               add_kind(el, bg, walk_addr(dr[el], i), k0[el]);
               add_kind(el, bg, walk_addr(dr[el], i), k1[el]);
            end
      for (int ln = 0; ln < NB; ln++)
         for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] d0 = bgword(1, a);
            logic [DW-1:0] ex = ~d0;
            for (int m = 0; m <= ln; m++) ex[m*8 +: 8] = d0[m*8 +: 8];
            add_op(7, a, 1, 1 << ln, d0);
            add_op(7, a, 0, (1 << NB) - 1, ex);
         end
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // One run compared against the reference on every cycle.
   task automatic run_case(input int fmode, input int pulse_at, output int first_fail);
      int tot;
      int k;
      logic [DW-1:0] rv;
      fault_mode = fmode;
      first_fail = -1;
      tot = q_addr.size();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int n = 1; n <= tot + RL + 3; n++) begin
         k = n - 2;
         if (k >= 0 && k < tot) begin
            chk(mem_ce == 1'b1, "R3", "access present", 64'(mem_ce), 1);
            chk(mem_addr == AW'(q_addr[k]), "R4", "address", 64'(mem_addr), 64'(q_addr[k]));
            chk(mem_we == (q_we[k] != 0), "R3", "write enable", 64'(mem_we), 64'(q_we[k]));
            chk(mem_be == NB'(q_be[k]), (q_el[k] == 7) ? "R7" : "R8", "byte enables",
                64'(mem_be), 64'(q_be[k]));
            if (q_we[k] != 0)
               chk(mem_wdata == q_dat[k], (q_el[k] == 7) ? "R7" : "R5", "write data",
                   64'(mem_wdata), 64'(q_dat[k]));
            else begin
               rv = peek(q_addr[k]);
               if (rv != q_dat[k] && first_fail < 0) first_fail = n + RL + 1;
            end
         end else begin
            chk(mem_ce == 1'b0, "R3", "no access outside run", 64'(mem_ce), 0);
         end
         chk(fail == (first_fail >= 0 && n >= first_fail), "R9", "fail timing",
             64'(fail), 64'(first_fail >= 0 && n >= first_fail));
         chk(done == (n == tot + RL + 2), "R11", "done timing", 64'(done), 64'(n == tot + RL + 2));
         start = (n == pulse_at);
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int ff;
      bit saw_done;
      rst_n = 1'b0; test_mode = 1'b0; start = 1'b0;
      func_ce = 1'b1; func_we = 1'b1; func_addr = AW'(9);
      func_be = NB'(2); func_wdata = DW'(16'h1234);
      for (int i = 0; i < 3; i++) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state and functional pass-through
      chk(fail == 1'b0, "R10", "fail after reset", 64'(fail), 0);
      chk(done == 1'b0, "R11", "done after reset", 64'(done), 0);
      chk(mem_ce == 1'b1 && mem_we == 1'b1 && mem_addr == AW'(9) && mem_be == NB'(2)
          && mem_wdata == DW'(16'h1234), "R1", "pass-through",
          64'({mem_ce, mem_we, mem_addr, mem_be, mem_wdata}),
          64'({1'b1, 1'b1, AW'(9), NB'(2), DW'(16'h1234)}));
      // R2: start with test mode low is ignored
      start = 1'b1; @(negedge clk); start = 1'b0;
      saw_done = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (done) saw_done = 1'b1;
         @(negedge clk);
      end
      chk(!saw_done && mem_addr == AW'(9), "R2", "start ignored out of test mode",
          64'(saw_done), 0);
      // R1: test mode idle keeps memory deselected
      func_ce = 1'b0; func_we = 1'b0; test_mode = 1'b1;
      @(negedge clk);
      chk(mem_ce == 1'b0 && mem_we == 1'b0, "R1", "idle in test mode", 64'(mem_ce), 0);

      build_ops();

      run_case(0, -1, ff);
      chk(fail == 1'b0 && ff < 0, "R9", "clean run passes", 64'(fail), 0);
      run_case(0, 60, ff);
      chk(fail == 1'b0, "R2", "start during run ignored", 64'(fail), 0);
      run_case(1, -1, ff);
      chk(fail == 1'b1 && ff >= 0, "R9", "stuck bit detected", 64'(fail), 1);
      for (int i = 0; i < 4; i++) @(negedge clk);
      chk(fail == 1'b1, "R10", "fail holds while idle", 64'(fail), 1);
      run_case(0, -1, ff);
      chk(fail == 1'b0, "R10", "fail cleared by new start", 64'(fail), 0);
      run_case(2, -1, ff);
      chk(fail == 1'b1, "R6", "read disturb detected", 64'(fail), 1);
      run_case(3, -1, ff);
      chk(fail == 1'b1, "R7", "enable short detected", 64'(fail), 1);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule